// File: doc/BRIEF.md
# Fan Spin-Up Sequencer

This block runs the start-up phase of a cooling fan before ordinary PWM control takes over. When a start request arrives, it samples a configuration byte. The byte gives a spin-up duration, a spin-up duty and an early-exit option driven by a tachometer. The block then drives a spin-up duty for that duration. Time is measured in pulses of an external time-base tick, with one pulse every 0.05 s. If the early-exit option is armed, spin-up also ends as soon as an external comparator reports that the fan has reached its minimum speed. Whichever of the two events comes first ends the phase.

The configuration byte uses these fields:
- bits 2:0 are the time code.
- bits 4:3 are the duty code.
- bit 5 is the early-exit flag.
- bits 7:6 carry nothing.

While spin-up runs, the PWM value that the block passes on from the normal control path is reported as zero. Once spin-up ends, that value is passed through again. All outputs are registered. Reset is synchronous and active high.

Top module: `fan_spinup_seq`

## Requirements
- R1: While reset is high, spin_active, spin_duty and pwm_value_rpt are 0 after the clock edge.
- R2: With time code k in 1..7 and no bypass, spin_active rises at the edge that samples start_req. It falls at the edge that samples the 2^(k-1)-th tick counted afterwards.
- R3: Time code 000 (bits 2:0) makes a start request produce no spin-up, whatever bits 5:3 and tach_mode_en hold.
- R4: Duty code 00 (bits 4:3) produces no spin-up unless early exit is effective. Early exit is effective only when bit 5 = 1 and tach_mode_en = 1. In that case spin-up runs at full-scale duty.
- R5: When early exit is not effective, spin_duty during spin-up is set by the duty code against a full scale of 64: code 01 gives 32, code 10 gives 48 and code 11 gives 64. spin_duty is 0 whenever spin_active is 0.
- R6: When early exit is effective, spin_duty is 64 whatever the duty code, and min_speed_ok sampled during spin-up ends it at that edge. When early exit is not effective, min_speed_ok has no effect.
- R7: pwm_value_rpt is 0 in every cycle in which spin_active is 1. In all other cycles it equals the pwm_value_in sampled at the same edge.
- R8: A start request during an active spin-up recaptures the configuration and restarts the tick count from zero. If the new configuration bypasses, spin-up ends at that edge.
- R9: Changes of cfg_byte or tach_mode_en after the start edge do not alter the duration, the duty or the early-exit behaviour of the running spin-up.
- R10: A tick sampled at the same edge as start_req is not counted. Bits 7:6 of cfg_byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte | input | 8 | Spin-up configuration: bit 5 early exit, bits 4:3 duty code, bits 2:0 time code |
| tach_mode_en | input | 1 | Tachometer mode; required for early exit |
| start_req | input | 1 | One-cycle request to start (or restart) spin-up |
| tick | input | 1 | Time-base pulse, one per 0.05 s |
| min_speed_ok | input | 1 | Tachometer comparator: minimum speed reached |
| pwm_value_in | input | PWM_W (6) | PWM value from the normal control path |
| spin_active | output | 1 | Spin-up phase in progress |
| spin_duty | output | DUTY_W (7) | Duty to apply during spin-up, full scale 64 |
| pwm_value_rpt | output | PWM_W (6) | Reported PWM value, zero during spin-up |

## Verification
A corrupted tick counter or stored target moves the falling edge of spin_active. That error becomes visible at the very tick that should end the phase, or one tick before or after it. A wrong captured duty or early-exit flag shows on spin_duty in the first cycle after the start edge. It can also show when min_speed_ok is pulsed and spin-up fails to end in the following cycle, or ends when it should not. The sweep scrambles cfg_byte and tach_mode_en right after each start edge, so state that is not properly captured shows as a wrong duration or duty within the same run.

// File: rtl/fan_spinup_pkg.sv
`timescale 1ns/1ps
package fan_spinup_pkg;

  // Width of the duration selector field; code k selects 2^(k-1) ticks.
  localparam int TIME_CODE_W = 3;
  // Largest shift the duration selector can ask for.
  localparam int MAX_SHIFT   = (1 << TIME_CODE_W) - 2;
  // Tick counter width, wide enough to hold the longest target.
  localparam int TICK_CNT_W  = MAX_SHIFT + 1;

  typedef struct packed {
    logic                   fast_exit;
    logic [1:0]             duty_sel;
    logic [TIME_CODE_W-1:0] time_sel;
  } spin_cfg_t;

  localparam int CFG_USED_W = $bits(spin_cfg_t);

endpackage

// File: rtl/spinup_cfg_decode.sv
`timescale 1ns/1ps
module spinup_cfg_decode
  import fan_spinup_pkg::*;
#(
  parameter int DUTY_FRAC_W = 6,
  localparam int DUTY_W     = DUTY_FRAC_W + 1
) (
  input  spin_cfg_t               cfg,
  input  logic                    tach_mode_en,
  output logic                    bypass,
  output logic                    fast_eff,
  output logic [DUTY_W-1:0]       duty,
  output logic [TICK_CNT_W-1:0]   ticks
);

  localparam logic [DUTY_W-1:0] DUTY_FULL = DUTY_W'(1) << DUTY_FRAC_W;
  localparam logic [DUTY_W-1:0] DUTY_HALF = DUTY_FULL >> 1;
  localparam logic [DUTY_W-1:0] DUTY_MID  = DUTY_HALF + (DUTY_HALF >> 1);

  logic time_zero;

  always_comb begin
    fast_eff  = cfg.fast_exit & tach_mode_en;
    time_zero = (cfg.time_sel == '0);
    bypass    = time_zero | ((cfg.duty_sel == 2'b00) & ~fast_eff);
  end

  always_comb begin
    if (fast_eff) begin
      duty = DUTY_FULL;
    end else begin
      unique case (cfg.duty_sel)
        2'b01:   duty = DUTY_HALF;
        2'b10:   duty = DUTY_MID;
        2'b11:   duty = DUTY_FULL;
        default: duty = '0;
      endcase
    end
  end

  always_comb begin
    if (time_zero) begin
      ticks = '0;
    end else begin
      ticks = TICK_CNT_W'(1) << (cfg.time_sel - TIME_CODE_W'(1));
    end
  end

endmodule

// File: rtl/spinup_tick_timer.sv
`timescale 1ns/1ps
module spinup_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] target_in,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      tgt_q <= target_in;
    end else if (run && tick) begin
      cnt_q <= cnt_inc;
    end
  end

  assign expire = run & tick & ~load & (cnt_inc == tgt_q);

endmodule

// File: rtl/spinup_out_regs.sv
`timescale 1ns/1ps
module spinup_out_regs #(
  parameter int DUTY_W = 7,
  parameter int PWM_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_d,
  input  logic [DUTY_W-1:0] duty_d,
  input  logic [PWM_W-1:0]  pwm_in,
  output logic [DUTY_W-1:0] duty_q,
  output logic [PWM_W-1:0]  pwm_rpt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q    <= '0;
      pwm_rpt_q <= '0;
    end else begin
      duty_q    <= active_d ? duty_d : '0;
      pwm_rpt_q <= active_d ? '0 : pwm_in;
    end
  end

endmodule

// File: rtl/fan_spinup_seq.sv
`timescale 1ns/1ps
module fan_spinup_seq
  import fan_spinup_pkg::*;
#(
  parameter int DUTY_FRAC_W = 6,
  parameter int PWM_W       = 6,
  localparam int DUTY_W     = DUTY_FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfg_byte,
  input  logic              tach_mode_en,
  input  logic              start_req,
  input  logic              tick,
  input  logic              min_speed_ok,
  input  logic [PWM_W-1:0]  pwm_value_in,
  output logic              spin_active,
  output logic [DUTY_W-1:0] spin_duty,
  output logic [PWM_W-1:0]  pwm_value_rpt
);

  spin_cfg_t               cfg_in;
  logic [1:0]              unused_cfg_hi;
  logic                    dec_bypass;
  logic                    dec_fast;
  logic [DUTY_W-1:0]       dec_duty;
  logic [TICK_CNT_W-1:0]   dec_ticks;

  logic                    active_q;
  logic                    ft_cap_q;
  logic [DUTY_W-1:0]       duty_cap_q;
  logic                    active_d;
  logic [DUTY_W-1:0]       duty_d;
  logic                    timer_expire;
  logic                    speed_end;

  assign cfg_in        = spin_cfg_t'(cfg_byte[CFG_USED_W-1:0]);
  assign unused_cfg_hi = cfg_byte[7:6];

  spinup_cfg_decode #(
    .DUTY_FRAC_W (DUTY_FRAC_W)
  ) u_decode (
    .cfg          (cfg_in),
    .tach_mode_en (tach_mode_en),
    .bypass       (dec_bypass),
    .fast_eff     (dec_fast),
    .duty         (dec_duty),
    .ticks        (dec_ticks)
  );

  spinup_tick_timer #(
    .CNT_W (TICK_CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (start_req),
    .target_in (dec_ticks),
    .run       (active_q),
    .tick      (tick),
    .expire    (timer_expire)
  );

  always_comb begin
    speed_end = active_q & ft_cap_q & min_speed_ok;
    if (start_req) begin
      active_d = ~dec_bypass;
      duty_d   = dec_duty;
    end else begin
      active_d = active_q & ~timer_expire & ~speed_end;
      duty_d   = duty_cap_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      ft_cap_q   <= 1'b0;
      duty_cap_q <= '0;
    end else begin
      active_q <= active_d;
      if (start_req) begin
        ft_cap_q   <= dec_fast;
        duty_cap_q <= dec_duty;
      end
    end
  end

  spinup_out_regs #(
    .DUTY_W (DUTY_W),
    .PWM_W  (PWM_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .active_d  (active_d),
    .duty_d    (duty_d),
    .pwm_in    (pwm_value_in),
    .duty_q    (spin_duty),
    .pwm_rpt_q (pwm_value_rpt)
  );

  assign spin_active = active_q;

endmodule

// File: rtl/fan_spinup_chk.sv
`timescale 1ns/1ps
module fan_spinup_chk #(
  parameter int DUTY_FRAC_W = 6,
  localparam int DUTY_W     = DUTY_FRAC_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start_req,
  input logic [2:0]        cfg_time,
  input logic              min_speed_ok,
  input logic              spin_active,
  input logic [DUTY_W-1:0] spin_duty,
  input logic              pwm_rpt_zero,
  input logic              ft_cap
);

  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(1) << DUTY_FRAC_W;
  localparam logic [DUTY_W-1:0] HALF = FULL >> 1;
  localparam logic [DUTY_W-1:0] MID  = HALF + (HALF >> 1);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!spin_active && spin_duty == '0));

  p_time_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (start_req && cfg_time == 3'b000) |=> !spin_active);

  p_duty_legal_r5: assert property (@(posedge clk) disable iff (rst)
    spin_active |-> (spin_duty == HALF || spin_duty == MID || spin_duty == FULL));

  p_duty_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !spin_active |-> spin_duty == '0);

  p_speed_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (spin_active && ft_cap && min_speed_ok && !start_req) |=> !spin_active);

  p_fast_full_r6: assert property (@(posedge clk) disable iff (rst)
    (spin_active && ft_cap) |-> spin_duty == FULL);

  p_report_zero_r7: assert property (@(posedge clk) disable iff (rst)
    spin_active |-> pwm_rpt_zero);

  p_rise_needs_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(spin_active) |-> $past(start_req));

  p_duty_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (spin_active && !start_req) |=> (!spin_active || $stable(spin_duty)));

endmodule

bind fan_spinup_seq fan_spinup_chk #(
  .DUTY_FRAC_W (DUTY_FRAC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_req    (start_req),
  .cfg_time     (cfg_byte[2:0]),
  .min_speed_ok (min_speed_ok),
  .spin_active  (spin_active),
  .spin_duty    (spin_duty),
  .pwm_rpt_zero (pwm_value_rpt == '0),
  .ft_cap       (ft_cap_q)
);

// File: tb/fan_spinup_seq_bench.sv
`timescale 1ns/1ps
module fan_spinup_seq_bench;

  localparam int DUTY_FRAC_W = 6;
  localparam int PWM_W       = 6;
  localparam int DUTY_W      = DUTY_FRAC_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        cfg_byte = 8'h00;
  logic              tach_mode_en = 1'b0;
  logic              start_req = 1'b0;
  logic              tick = 1'b0;
  logic              min_speed_ok = 1'b0;
  logic [PWM_W-1:0]  pwm_value_in = '0;
  logic              spin_active;
  logic [DUTY_W-1:0] spin_duty;
  logic [PWM_W-1:0]  pwm_value_rpt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fan_spinup_seq #(
    .DUTY_FRAC_W (DUTY_FRAC_W),
    .PWM_W       (PWM_W)
  ) u_fan_spinup_seq (
    .clk           (clk),
    .rst           (rst),
    .cfg_byte      (cfg_byte),
    .tach_mode_en  (tach_mode_en),
    .start_req     (start_req),
    .tick          (tick),
    .min_speed_ok  (min_speed_ok),
    .pwm_value_in  (pwm_value_in),
    .spin_active   (spin_active),
    .spin_duty     (spin_duty),
    .pwm_value_rpt (pwm_value_rpt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic expect_state(input string req, input bit act_exp, input int duty_exp, input int rpt_exp);
    chk(spin_active == act_exp, req, int'(spin_active), int'(act_exp));
    chk(int'(spin_duty) == duty_exp, req, int'(spin_duty), duty_exp);
    chk(int'(pwm_value_rpt) == rpt_exp, req, int'(pwm_value_rpt), rpt_exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // Full sweep case: start with cfg, scramble inputs, tick to the end.
  task automatic run_case(input logic [7:0] cfg, input bit tm, input bit with_ms);
    int  tcode;
    int  dcode;
    bit  fe;
    bit  byp;
    int  tgt;
    int  dexp;
    int  pv;
    bit  alive;
    tcode = int'(cfg[2:0]);
    dcode = int'(cfg[4:3]);
    fe    = cfg[5] & tm;
    byp   = (tcode == 0) || (dcode == 0 && !fe);
    tgt   = (tcode == 0) ? 0 : (1 << (tcode - 1));
    if (fe)              dexp = 64;
    else if (dcode == 1) dexp = 32;
    else if (dcode == 2) dexp = 48;
    else                 dexp = 64;
    pv = int'(cfg[5:0] ^ 6'h2B);

    @(negedge clk);
    cfg_byte = cfg; tach_mode_en = tm; start_req = 1'b1;
    pwm_value_in = PWM_W'(pv);
    @(negedge clk);
    start_req = 1'b0;
    cfg_byte = ~cfg;            // R9: scrambled after the start edge
    tach_mode_en = ~tm;
    if (byp) expect_state((tcode == 0) ? "R3" : "R4", 1'b0, 0, pv);
    else     expect_state(fe ? "R6" : "R5", 1'b1, dexp, 0);

    alive = !byp;
    for (int n = 1; alive && n <= tgt; n++) begin
      pulse_tick();
      alive = (n < tgt);
      chk(spin_active == alive, "R2", int'(spin_active), int'(alive));
      if (with_ms && n == 1 && alive) begin
        @(negedge clk) min_speed_ok = 1'b1;
        @(negedge clk) min_speed_ok = 1'b0;
        if (fe) alive = 1'b0;
        chk(spin_active == alive, "R6", int'(spin_active), int'(alive));
      end
    end
    @(negedge clk);
    expect_state("R7", 1'b0, 0, pv);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    pwm_value_in = 6'd5;
    repeat (3) @(negedge clk);
    expect_state("R1", 1'b0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R7", 1'b0, 0, 5);

    // Sweep of every used configuration value, with varied spare bits (R10)
    for (int c = 0; c < 64; c++) begin
      for (int tm = 0; tm < 2; tm++) begin
        for (int ms = 0; ms < 2; ms++) begin
          logic [7:0] cv;
          cv = {c[1] ^ ms[0], c[3] ^ tm[0], c[5:0]};
          run_case(cv, tm[0], ms[0]);
        end
      end
    end

    // R8 / R10: restart mid-run with a coincident tick
    @(negedge clk);
    cfg_byte = 8'h1B; tach_mode_en = 1'b0; start_req = 1'b1; pwm_value_in = 6'd9;
    @(negedge clk) start_req = 1'b0;
    expect_state("R8", 1'b1, 64, 0);
    repeat (3) pulse_tick();
    chk(spin_active == 1'b1, "R8", int'(spin_active), 1);
    @(negedge clk);
    cfg_byte = 8'h0A; start_req = 1'b1; tick = 1'b1;
    @(negedge clk);
    start_req = 1'b0; tick = 1'b0;
    expect_state("R8", 1'b1, 32, 0);
    pulse_tick();
    chk(spin_active == 1'b1, "R10", int'(spin_active), 1);
    pulse_tick();
    chk(spin_active == 1'b0, "R8", int'(spin_active), 0);

    // R8: restart with a bypassing configuration cancels spin-up
    @(negedge clk);
    cfg_byte = 8'h1B; start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    pulse_tick();
    chk(spin_active == 1'b1, "R8", int'(spin_active), 1);
    @(negedge clk);
    cfg_byte = 8'h18; start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    expect_state("R8", 1'b0, 0, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule